// File: doc/BRIEF.md
# Single-Wire Bus Master (HDQ / 1-Wire)

This block is a memory-mapped master for a single open-drain data line. A mode bit selects one of two protocols: HDQ or 1-Wire. Each protocol has its own set of timing parameters, all counted in clock cycles. Software talks to the block through a small register bus. It loads a byte to send, picks the operation in the control register and sets a self-clearing GO bit. It then waits for the interrupt or polls the interrupt status register, and collects any received byte.

Three operations exist, and the INIT and direction bits choose between them. The first is a break/reset pulse that also checks whether a slave is present. The second is a byte write, sent least significant bit first. The third is a byte read, also least significant bit first. A single-bit mode reuses the same slot logic to move only one bit, which is what a ROM search loop needs. The block drives the line low through an output enable and watches it through a separate input pin.

Top module: `swire_master`

## Requirements
- R1: After reset the control register reads 0x00, interrupt status reads 0x00, the line is released, the interrupt output is low and system status bit 0 reads 1.
- R2: A control write with GO (bit 4) set but clock enable (bit 5) clear starts nothing: the line stays released and GO reads back 0.
- R3: With INIT (bit 2) and GO set, the line is driven low for the break-low count and the operation lasts the break length. The presence bit (bit 3) is then loaded from the line level at the presence sample count: a low level means a slave is present. Interrupt status bit 0 is set, and GO and INIT read back 0.
- R4: A write (direction bit 1 = 0) sends the transmit-data byte least significant bit first. Each slot lasts the slot length and holds the line low for the short count for a 1 and the long count for a 0. At the end, interrupt status bit 2 is set.
- R5: A read (direction = 1) holds the line low for the short count in each slot and samples it at the sample count. The eight samples are assembled least significant bit first into receive data, and interrupt status bit 1 is set.
- R6: In single-bit mode (control bit 7) a transfer is one slot long. A write sends transmit-data bit 0. A read puts the sampled bit into receive-data bit 0, and the other receive bits read 0.
- R7: Control bit 0 = 0 selects the HDQ timing set and 1 selects the 1-Wire timing set, for breaks and for bit slots.
- R8: Reading interrupt status (offset 0x10) returns the flags and clears all three of them.
- R9: The interrupt output is high exactly when interrupt enable (control bit 6) is set and any interrupt status bit is set.
- R10: A control write made while GO is set changes only interrupt enable and clock enable. The running operation, its waveform, and the stored INIT, direction, single and mode bits are unaffected.
- R11: Writing 1 to system configuration bit 1 (offset 0x14) is a soft reset. System status bit 0 reads 0 in the following cycle and 1 after that, and control, interrupt status, receive data and configuration all return to 0. Configuration bit 0 is a read/write auto-idle bit.
- R12: Offset 0x00 returns the major version in bits 7:4 and the minor version in bits 3:0. Offsets 0x04 and 0x08 are transmit and receive data, and 0x18 is system status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| line_oe | output | 1 | 1 pulls the single-wire line low |
| line_in | input | 1 | Level sensed on the line |
| irq | output | 1 | Interrupt request |

## Verification
The bench sets both timing sets to short, distinct values. In the HDQ set, break low is 12, presence sample 18, break length 24, slot 14, short low 3, long low 9 and sample 6. In the 1-Wire set they are 8, 12, 16, 10, 2, 6 and 4. Because the values are short, every bit slot, break and sample point is compared against the reference cycle by cycle in a run of a few thousand clocks. Because the two sets differ, a swapped mode selection changes the waveform at once. A slave model in the bench pulls the line low around the sample points, so presence, absence and arbitrary read patterns can all be reached.

// File: rtl/swire_pkg.sv
package swire_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFF_REV    = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_TXD    = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_RXD    = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_ISR    = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_SYSCFG = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_SYSSTA = 5'h18;

  localparam int CB_SINGLE = 7;
  localparam int CB_IE     = 6;
  localparam int CB_CLKEN  = 5;
  localparam int CB_GO     = 4;
  localparam int CB_PRES   = 3;
  localparam int CB_INIT   = 2;
  localparam int CB_DIR    = 1;
  localparam int CB_MODE   = 0;

  typedef enum logic [1:0] {OP_BRK, OP_RD, OP_WR} op_e;
  typedef enum logic [1:0] {ENG_IDLE, ENG_BRK, ENG_SLOT} eng_state_e;
endpackage

// File: rtl/swire_engine.sv
module swire_engine
  import swire_pkg::*;
#(
  parameter int HQ_BRK_LOW  = 200,
  parameter int HQ_BRK_SAMP = 260,
  parameter int HQ_BRK_LEN  = 320,
  parameter int HQ_SLOT     = 190,
  parameter int HQ_LOW1     = 40,
  parameter int HQ_LOW0     = 120,
  parameter int HQ_SAMP     = 80,
  parameter int OW_BRK_LOW  = 480,
  parameter int OW_BRK_SAMP = 550,
  parameter int OW_BRK_LEN  = 960,
  parameter int OW_SLOT     = 70,
  parameter int OW_LOW1     = 6,
  parameter int OW_LOW0     = 60,
  parameter int OW_SAMP     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              st_init,
  input  logic              st_dir,
  input  logic              st_single,
  input  logic              st_mode,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              line_in,
  output logic              line_oe,
  output logic              done,
  output op_e               done_kind,
  output logic [DATA_W-1:0] rx_byte,
  output logic              presence
);
  localparam int MAX_H = (HQ_BRK_LEN > HQ_SLOT) ? HQ_BRK_LEN : HQ_SLOT;
  localparam int MAX_O = (OW_BRK_LEN > OW_SLOT) ? OW_BRK_LEN : OW_SLOT;
  localparam int MAX_T = (MAX_H > MAX_O) ? MAX_H : MAX_O;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam int BW    = $clog2(DATA_W);

  eng_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic              pres_q, pres_d, mode_q, mode_d, dir_q, dir_d, single_q, single_d;
  logic [CW-1:0]     t_blow, t_bsamp, t_blen, t_slot, t_low1, t_low0, t_samp;
  logic              last_tick, samp_tick, last_bit;

  // timing set chosen by the mode latched at start
  always_comb begin
    if (mode_q) begin
      t_blow = CW'(OW_BRK_LOW); t_bsamp = CW'(OW_BRK_SAMP); t_blen = CW'(OW_BRK_LEN);
      t_slot = CW'(OW_SLOT); t_low1 = CW'(OW_LOW1); t_low0 = CW'(OW_LOW0); t_samp = CW'(OW_SAMP);
    end else begin
      t_blow = CW'(HQ_BRK_LOW); t_bsamp = CW'(HQ_BRK_SAMP); t_blen = CW'(HQ_BRK_LEN);
      t_slot = CW'(HQ_SLOT); t_low1 = CW'(HQ_LOW1); t_low0 = CW'(HQ_LOW0); t_samp = CW'(HQ_SAMP);
    end
  end

  always_comb begin
    last_tick = (state_q == ENG_BRK) ? (cnt_q == t_blen - 1'b1) : (cnt_q == t_slot - 1'b1);
    samp_tick = (state_q == ENG_BRK) ? (cnt_q == t_bsamp) : (cnt_q == t_samp);
    last_bit  = single_q || (bit_q == BW'(DATA_W - 1));
    done      = ((state_q == ENG_BRK) && last_tick) ||
                ((state_q == ENG_SLOT) && last_tick && last_bit);
    done_kind = (state_q == ENG_BRK) ? OP_BRK : (dir_q ? OP_RD : OP_WR);
    case (state_q)
      ENG_BRK:  line_oe = (cnt_q < t_blow);
      ENG_SLOT: line_oe = (cnt_q < ((dir_q || sh_q[0]) ? t_low1 : t_low0));
      default:  line_oe = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q; rx_d = rx_q;
    pres_d = pres_q; mode_d = mode_q; dir_d = dir_q; single_d = single_q;
    case (state_q)
      ENG_IDLE: if (start) begin
        state_d  = st_init ? ENG_BRK : ENG_SLOT;
        cnt_d    = '0;
        bit_d    = '0;
        sh_d     = tx_byte;
        mode_d   = st_mode;
        dir_d    = st_dir;
        single_d = st_single;
      end
      ENG_BRK: begin
        cnt_d = cnt_q + 1'b1;
        if (samp_tick) pres_d = !line_in;
        if (last_tick) state_d = ENG_IDLE;
      end
      ENG_SLOT: begin
        cnt_d = cnt_q + 1'b1;
        if (samp_tick && dir_q)
          rx_d = single_q ? {{(DATA_W-1){1'b0}}, line_in} : {line_in, rx_q[DATA_W-1:1]};
        if (last_tick) begin
          cnt_d = '0;
          if (last_bit) state_d = ENG_IDLE;
          else begin
            bit_d = bit_q + 1'b1;
            sh_d  = sh_q >> 1;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
    if (clr) state_d = ENG_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
      pres_q <= 1'b0; mode_q <= 1'b0; dir_q <= 1'b0; single_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d; rx_q <= rx_d;
      pres_q <= pres_d; mode_q <= mode_d; dir_q <= dir_d; single_q <= single_d;
    end
  end

  assign rx_byte  = rx_q;
  assign presence = pres_q;

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state_q == ENG_IDLE));
  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_IDLE) |-> !line_oe);
endmodule

// File: rtl/swire_regs.sv
module swire_regs
  import swire_pkg::*;
#(
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_done,
  input  op_e               eng_kind,
  input  logic [DATA_W-1:0] eng_rx,
  input  logic              eng_pres,
  output logic              start,
  output logic              st_init,
  output logic              st_dir,
  output logic              st_single,
  output logic              st_mode,
  output logic [DATA_W-1:0] tx_byte,
  output logic              soft_clr,
  output logic              irq
);
  localparam logic [DATA_W-1:0] REV_VAL = {4'(REV_MAJOR), 4'(REV_MINOR)};

  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic single_q, single_d, ie_q, ie_d, clken_q, clken_d, go_q, go_d;
  logic pres_q, pres_d, init_q, init_d, dir_q, dir_d, mode_q, mode_d;
  logic [2:0] flags_q, flags_d, set_f;
  logic auto_q, auto_d, srst_q, srst_d, rdone_q, rdone_d;
  logic wr_ctrl, wr_tx, wr_cfg, rd_isr;

  always_comb begin
    wr_ctrl   = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
    wr_tx     = bus_sel && bus_wr && (bus_addr == OFF_TXD);
    wr_cfg    = bus_sel && bus_wr && (bus_addr == OFF_SYSCFG);
    rd_isr    = bus_sel && !bus_wr && (bus_addr == OFF_ISR);
    start     = wr_ctrl && bus_wdata[CB_GO] && bus_wdata[CB_CLKEN] && !go_q && !srst_q;
    st_init   = bus_wdata[CB_INIT];
    st_dir    = bus_wdata[CB_DIR];
    st_single = bus_wdata[CB_SINGLE];
    st_mode   = bus_wdata[CB_MODE];
  end

  always_comb begin
    tx_d = tx_q; rx_d = rx_q; single_d = single_q; ie_d = ie_q; clken_d = clken_q;
    go_d = go_q; pres_d = pres_q; init_d = init_q; dir_d = dir_q; mode_d = mode_q;
    auto_d = auto_q; set_f = 3'b000;
    if (wr_ctrl) begin
      ie_d    = bus_wdata[CB_IE];
      clken_d = bus_wdata[CB_CLKEN];
      if (!go_q) begin
        single_d = bus_wdata[CB_SINGLE];
        init_d   = bus_wdata[CB_INIT];
        dir_d    = bus_wdata[CB_DIR];
        mode_d   = bus_wdata[CB_MODE];
        go_d     = start;
      end
    end
    if (wr_tx)  tx_d = bus_wdata;
    if (wr_cfg) auto_d = bus_wdata[0];
    if (eng_done) begin
      go_d   = 1'b0;
      init_d = 1'b0;
      case (eng_kind)
        OP_BRK: begin set_f[0] = 1'b1; pres_d = eng_pres; end
        OP_RD:  begin set_f[1] = 1'b1; rx_d = eng_rx; end
        default: set_f[2] = 1'b1;
      endcase
    end
    flags_d = (rd_isr ? 3'b000 : flags_q) | set_f;
    srst_d  = wr_cfg && bus_wdata[1];
    rdone_d = !srst_d;
    if (srst_q) begin
      tx_d = '0; rx_d = '0; single_d = 1'b0; ie_d = 1'b0; clken_d = 1'b0; go_d = 1'b0;
      pres_d = 1'b0; init_d = 1'b0; dir_d = 1'b0; mode_d = 1'b0; auto_d = 1'b0;
      flags_d = 3'b000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0; rx_q <= '0; single_q <= 1'b0; ie_q <= 1'b0; clken_q <= 1'b0;
      go_q <= 1'b0; pres_q <= 1'b0; init_q <= 1'b0; dir_q <= 1'b0; mode_q <= 1'b0;
      flags_q <= 3'b000; auto_q <= 1'b0; srst_q <= 1'b0; rdone_q <= 1'b0;
    end else begin
      tx_q <= tx_d; rx_q <= rx_d; single_q <= single_d; ie_q <= ie_d; clken_q <= clken_d;
      go_q <= go_d; pres_q <= pres_d; init_q <= init_d; dir_q <= dir_d; mode_q <= mode_d;
      flags_q <= flags_d; auto_q <= auto_d; srst_q <= srst_d; rdone_q <= rdone_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_REV:    bus_rdata = REV_VAL;
      OFF_TXD:    bus_rdata = tx_q;
      OFF_RXD:    bus_rdata = rx_q;
      OFF_CTRL:   bus_rdata = {single_q, ie_q, clken_q, go_q, pres_q, init_q, dir_q, mode_q};
      OFF_ISR:    bus_rdata = {5'b0, flags_q};
      OFF_SYSCFG: bus_rdata = {7'b0, auto_q};
      OFF_SYSSTA: bus_rdata = {7'b0, rdone_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign tx_byte  = tx_q;
  assign soft_clr = srst_q;
  assign irq      = ie_q && (flags_q != 3'b000);

  // R3
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> go_q);
  // R8
  isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_isr && !eng_done && !srst_q) |=> (flags_q == 3'b000));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && wr_ctrl && !eng_done && !srst_q) |=>
      ($stable(init_q) && $stable(dir_q) && $stable(mode_q) && $stable(single_q) && go_q));
  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!go_q && (flags_q == 3'b000) && (rx_q == '0) && rdone_q));
endmodule

// File: rtl/swire_master.sv
module swire_master
  import swire_pkg::*;
#(
  parameter int REV_MAJOR   = 2,
  parameter int REV_MINOR   = 1,
  parameter int HQ_BRK_LOW  = 200,
  parameter int HQ_BRK_SAMP = 260,
  parameter int HQ_BRK_LEN  = 320,
  parameter int HQ_SLOT     = 190,
  parameter int HQ_LOW1     = 40,
  parameter int HQ_LOW0     = 120,
  parameter int HQ_SAMP     = 80,
  parameter int OW_BRK_LOW  = 480,
  parameter int OW_BRK_SAMP = 550,
  parameter int OW_BRK_LEN  = 960,
  parameter int OW_SLOT     = 70,
  parameter int OW_LOW1     = 6,
  parameter int OW_LOW0     = 60,
  parameter int OW_SAMP     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       line_oe,
  input  logic       line_in,
  output logic       irq
);
  logic              start, st_init, st_dir, st_single, st_mode, soft_clr;
  logic              eng_done, eng_pres;
  op_e               eng_kind;
  logic [DATA_W-1:0] tx_byte, eng_rx;

  swire_regs #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done), .eng_kind(eng_kind),
    .eng_rx(eng_rx), .eng_pres(eng_pres), .start(start), .st_init(st_init), .st_dir(st_dir),
    .st_single(st_single), .st_mode(st_mode), .tx_byte(tx_byte), .soft_clr(soft_clr), .irq(irq)
  );

  swire_engine #(
    .HQ_BRK_LOW(HQ_BRK_LOW), .HQ_BRK_SAMP(HQ_BRK_SAMP), .HQ_BRK_LEN(HQ_BRK_LEN),
    .HQ_SLOT(HQ_SLOT), .HQ_LOW1(HQ_LOW1), .HQ_LOW0(HQ_LOW0), .HQ_SAMP(HQ_SAMP),
    .OW_BRK_LOW(OW_BRK_LOW), .OW_BRK_SAMP(OW_BRK_SAMP), .OW_BRK_LEN(OW_BRK_LEN),
    .OW_SLOT(OW_SLOT), .OW_LOW1(OW_LOW1), .OW_LOW0(OW_LOW0), .OW_SAMP(OW_SAMP)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .start(start), .st_init(st_init),
    .st_dir(st_dir), .st_single(st_single), .st_mode(st_mode), .tx_byte(tx_byte),
    .line_in(line_in), .line_oe(line_oe), .done(eng_done), .done_kind(eng_kind),
    .rx_byte(eng_rx), .presence(eng_pres)
  );
endmodule

// File: tb/sim_swire_master.sv
`timescale 1ns/1ps
module sim_swire_master;
  localparam int HBL = 12, HBS = 18, HBN = 24, HSL = 14, HL1 = 3, HL0 = 9, HSA = 6;
  localparam int OBL = 8,  OBS = 12, OBN = 16, OSL = 10, OL1 = 2, OL0 = 6, OSA = 4;
  localparam logic [4:0] A_REV = 5'h00, A_TX = 5'h04, A_RX = 5'h08, A_CTRL = 5'h0C,
                         A_ISR = 5'h10, A_CFG = 5'h14, A_STA = 5'h18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, slave_pull = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, txv = '0, rv;
  logic line_oe, line_in, irq;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;
  assign line_in = ~(line_oe | slave_pull);

  swire_master #(
    .REV_MAJOR(2), .REV_MINOR(1),
    .HQ_BRK_LOW(HBL), .HQ_BRK_SAMP(HBS), .HQ_BRK_LEN(HBN), .HQ_SLOT(HSL),
    .HQ_LOW1(HL1), .HQ_LOW0(HL0), .HQ_SAMP(HSA),
    .OW_BRK_LOW(OBL), .OW_BRK_SAMP(OBS), .OW_BRK_LEN(OBN), .OW_SLOT(OSL),
    .OW_LOW1(OL1), .OW_LOW0(OL0), .OW_SAMP(OSA)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_oe(line_oe), .line_in(line_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [4:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // cycle-by-cycle reference of the line during one operation
  task automatic run_op(input string tag, input logic [7:0] cv, input bit present,
                        input logic [7:0] sbits, input bit poke);
    int blow, bsamp, blen, slot, low1, low0, samp, len, nb, bad, bad_k;
    logic exp_oe, act_first, exp_first;
    bit init, dir, single;
    init = cv[2]; dir = cv[1]; single = cv[7];
    if (cv[0]) begin blow = OBL; bsamp = OBS; blen = OBN; slot = OSL; low1 = OL1; low0 = OL0; samp = OSA; end
    else       begin blow = HBL; bsamp = HBS; blen = HBN; slot = HSL; low1 = HL1; low0 = HL0; samp = HSA; end
    nb = single ? 1 : 8;
    len = init ? blen : nb * slot;
    bad = 0; bad_k = -1; act_first = 1'b0; exp_first = 1'b0;
    bw(A_CTRL, cv);
    for (int k = 0; k < len; k++) begin
      if (init) begin
        exp_oe = (k < blow);
        slave_pull = present && (k > blow) && (k <= bsamp + 1);
      end else begin
        int b, c;
        b = k / slot; c = k % slot;
        exp_oe = (c < ((dir || txv[b]) ? low1 : low0));
        slave_pull = dir && !sbits[b] && (c >= low1) && (c <= samp + 1);
      end
      if (poke && k == 0) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 8'h37;
      end
      if (poke && k == 1) begin bus_sel = 1'b0; bus_wr = 1'b0; end
      if (line_oe !== exp_oe) begin
        if (bad == 0) begin bad_k = k; act_first = line_oe; exp_first = exp_oe; end
        bad++;
      end
      @(negedge clk);
    end
    slave_pull = 1'b0;
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s line waveform at cycle %0d actual=%0b expected=%0b", tag, bad_k, act_first, exp_first);
    end
    chk({tag, " line released after op"}, {7'b0, line_oe}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    br(A_CTRL, rv); chk("R1 ctrl", rv, 8'h00);
    br(A_ISR, rv);  chk("R1 isr", rv, 8'h00);
    chk("R1 line", {7'b0, line_oe}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    br(A_STA, rv);  chk("R1 sysstatus", rv, 8'h01);
    // R12 revision
    br(A_REV, rv);  chk("R12 revision", rv, 8'h21);

    // R2 GO without clock enable
    bw(A_CTRL, 8'h12);
    repeat (3) begin chk("R2 line idle", {7'b0, line_oe}, 8'h00); @(negedge clk); end
    br(A_CTRL, rv); chk("R2 go clear", rv, 8'h02);

    // R3 R7 break with slave present, HDQ timing, irq enabled
    run_op("R3 break present HDQ", 8'h74, 1'b1, 8'h00, 1'b0);
    chk("R9 irq raised", {7'b0, irq}, 8'h01);
    br(A_CTRL, rv); chk("R3 ctrl after break", rv, 8'h68);
    br(A_ISR, rv);  chk("R8 isr timeout flag", rv, 8'h01);
    br(A_ISR, rv);  chk("R8 isr cleared", rv, 8'h00);
    chk("R9 irq low after clear", {7'b0, irq}, 8'h00);

    // R3 R7 break with no slave, 1-Wire timing
    run_op("R7 break absent 1-Wire", 8'h35, 1'b0, 8'h00, 1'b0);
    br(A_CTRL, rv); chk("R3 presence cleared", rv, 8'h21);
    br(A_ISR, rv);  chk("R3 isr timeout", rv, 8'h01);

    // R4 byte write, HDQ timing
    bw(A_TX, 8'hA5); txv = 8'hA5;
    run_op("R4 write A5 HDQ", 8'h30, 1'b0, 8'h00, 1'b0);
    chk("R9 irq masked", {7'b0, irq}, 8'h00);
    br(A_ISR, rv);  chk("R4 isr tx", rv, 8'h04);

    // R5 byte read, 1-Wire timing
    run_op("R5 read 3C 1-Wire", 8'h33, 1'b0, 8'h3C, 1'b0);
    br(A_RX, rv);   chk("R5 rx data", rv, 8'h3C);
    br(A_ISR, rv);  chk("R5 isr rx", rv, 8'h02);

    // R6 single-bit write of bit 0 = 0, then single-bit read of 1
    bw(A_TX, 8'h02); txv = 8'h02;
    run_op("R6 single write", 8'hB1, 1'b0, 8'h00, 1'b0);
    br(A_ISR, rv);  chk("R6 isr tx", rv, 8'h04);
    run_op("R6 single read", 8'hB3, 1'b0, 8'h01, 1'b0);
    br(A_RX, rv);   chk("R6 rx bit0", rv, 8'h01);

    // R5 byte read, HDQ timing
    run_op("R5 read 96 HDQ", 8'h32, 1'b0, 8'h96, 1'b0);
    br(A_RX, rv);   chk("R5 rx data HDQ", rv, 8'h96);
    br(A_ISR, rv);  chk("R5 isr rx HDQ", rv, 8'h02);

    // R10 control write while busy
    bw(A_TX, 8'hFF); txv = 8'hFF;
    run_op("R10 write during busy", 8'h30, 1'b0, 8'h00, 1'b1);
    br(A_CTRL, rv); chk("R10 ctrl kept", rv, 8'h20);
    chk("R9 irq off with ie clear", {7'b0, irq}, 8'h00);
    bw(A_CTRL, 8'h60);
    chk("R9 irq on when ie set", {7'b0, irq}, 8'h01);

    // R11 soft reset
    bw(A_CFG, 8'h03);
    br(A_STA, rv);  chk("R11 reset in progress", rv, 8'h00);
    br(A_STA, rv);  chk("R11 reset done", rv, 8'h01);
    br(A_CTRL, rv); chk("R11 ctrl cleared", rv, 8'h00);
    br(A_ISR, rv);  chk("R11 isr cleared", rv, 8'h00);
    br(A_RX, rv);   chk("R11 rx cleared", rv, 8'h00);
    br(A_CFG, rv);  chk("R11 cfg cleared", rv, 8'h00);
    chk("R11 irq low", {7'b0, irq}, 8'h00);
    bw(A_CFG, 8'h01);
    br(A_CFG, rv);  chk("R11 autoidle stored", rv, 8'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule